// File: doc/BRIEF.md
# Windowed Watchdog Timer with Key Sequence

This block is a watchdog counter that raises a reset request toward the system reset logic when software stops servicing it in time. Software configures it through a control write port. The control write carries a timeout code, a window-enable flag, a debug-stop flag and a write-only mask bit. Software services it through a separate service port that expects a two-byte key: first 0x55, then 0xAA. The counter advances only on cycles where the watchdog clock enable `tick` is high.

In window mode a service write is accepted only in the final quarter of the selected period, and any earlier service write raises a reset request. When the chip is halted in debug, the counter can be frozen. In special mode with debug active and freezing off, the block falls back to its longest timeout without a window. The parameter `EXP_TRIM` subtracts a fixed amount from every timeout exponent, so that short periods can be exercised. It must stay at 12 or below.

Top module: `wdog_window`

## Requirements
- R1: Timeout code (`ctl_rate`) 1..7 selects a period of 2^(E-EXP_TRIM) counted ticks, with E = 14, 16, 18, 20, 22, 23, 24 for codes 1, 2, 3, 4, 5, 6, 7. Counting the capturing edge of the accepted control write as edge e, and with `tick` held high, `rst_req` is high in the cycle after edge e+period and low before it.
- R2: With timeout code 0 the watchdog is disabled. The counter does not advance, no reset request is ever raised, and service writes of any value are ignored.
- R3: An accepted control write restarts the timeout period from zero. An expired period raises `rst_req`.
- R4: Writing 0x55 and then 0xAA to the service port restarts the period from zero, counting from the edge that captures 0xAA.
- R5: A service write of any value other than 0x55 or 0xAA, or a 0xAA that does not follow a 0x55, raises `rst_req` in the next cycle.
- R6: With the window flag set, a service write captured while the count is below three quarters of the period raises `rst_req`. Inside the final quarter, 0x55 may be written repeatedly. A following 0xAA restarts the period and closes the window again.
- R7: A control write with `ctl_mask` = 1 updates only the debug-stop flag. It leaves the timeout code and window flag unchanged, and it does not use up the single allowed configuration write.
- R8: With `special_mode` low, only the first unmasked control write after reset changes the timeout code and window flag, and later attempts do not restart the counter. With `special_mode` high, they can be rewritten at any time.
- R9: With the debug-stop flag set, the counter holds while `dbg_active` is high. With the flag clear, the counter keeps running during debug.
- R10: While the watchdog is enabled, `dbg_active` = 1, the debug-stop flag = 0 and `special_mode` = 1, the block uses the 2^(24-EXP_TRIM) period without a window, whatever the code and window flag hold.
- R11: `rst_req` is a single-cycle pulse per fault. Each fault clears the counter and the pending 0x55, so a 0xAA right after a fault is itself a fault.
- R12: The counter advances only on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Watchdog clock enable |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mask | input | 1 | Write-only mask: keep timeout code and window flag |
| ctl_win | input | 1 | Window-mode flag value |
| ctl_dbg_stop | input | 1 | Freeze-in-debug flag value |
| ctl_rate | input | 3 | Timeout code, 0 disables |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 8 | Service key byte |
| dbg_active | input | 1 | Debug halt is active |
| special_mode | input | 1 | Device runs in special mode |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach from the ports is the override in debug. It needs four inputs lined up at once, and its long period only shows if short-period window faults are shown to be absent. The bench programs the shortest code in window mode, enters the override, and services at once, which would be an early fault without the override. It then checks that no request appears for well past the short period and that expiry lands on the exact long-period edge. Random trials place the first key write at a random offset on either side of the window opening, and place the expiry check at a random gap around the period boundary.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;
    localparam int         MAX_EXP  = 24;

    typedef logic [2:0] rate_t;

    typedef struct packed {
        logic  win_en;
        logic  dbg_stop;
        rate_t rate;
    } wdog_cfg_t;

    typedef struct packed {
        logic  mask;
        logic  win_en;
        logic  dbg_stop;
        rate_t rate;
    } ctl_req_t;

    typedef enum logic [1:0] {
        SVC_NONE,
        SVC_ARM,
        SVC_FIRE,
        SVC_BAD
    } svc_kind_t;

    // Timeout exponent for a nonzero code; code 0 never counts.
    function automatic logic [4:0] rate_exp(rate_t r);
        case (r)
            3'd1:    return 5'd14;
            3'd2:    return 5'd16;
            3'd3:    return 5'd18;
            3'd4:    return 5'd20;
            3'd5:    return 5'd22;
            3'd6:    return 5'd23;
            default: return 5'd24;
        endcase
    endfunction

    function automatic svc_kind_t classify(logic wr, logic [7:0] d, logic armed);
        if (!wr)                     return SVC_NONE;
        if (d == KEY_ARM)            return SVC_ARM;
        if (d == KEY_FIRE && armed)  return SVC_FIRE;
        return SVC_BAD;
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_i,
    input  ctl_req_t  req_i,
    input  logic      special_i,
    output wdog_cfg_t cfg_o,
    output logic      load_o
);

    wdog_cfg_t cfg_q;
    logic      locked;
    logic      accept;

    assign accept = wr_i && !req_i.mask && (!locked || special_i);
    assign load_o = accept;
    assign cfg_o  = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            locked <= 1'b0;
        end else if (wr_i) begin
            cfg_q.dbg_stop <= req_i.dbg_stop;
            if (accept) begin
                cfg_q.win_en <= req_i.win_en;
                cfg_q.rate   <= req_i.rate;
                locked       <= 1'b1;
            end
        end
    end

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !special_i) |=> ($stable(cfg_q.rate) && $stable(cfg_q.win_en)));

    // R7
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && req_i.mask) |=> ($stable(cfg_q.rate) && $stable(cfg_q.win_en)));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int EXP_TRIM = 0
)(
    input  logic      clk,
    input  logic      rst,
    input  wdog_cfg_t cfg_i,
    input  logic      tick_i,
    input  logic      dbg_active_i,
    input  logic      special_i,
    input  logic      clear_i,
    output logic      en_o,
    output logic      win_mode_o,
    output logic      win_open_o,
    output logic      expire_o
);

    localparam int CW = MAX_EXP - EXP_TRIM + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;
    logic [CW-1:0] win_start;
    logic [4:0]    exp_sel;
    logic          en;
    logic          ovr;
    logic          frozen;
    logic          run;

    always_comb begin
        en        = (cfg_i.rate != '0);
        ovr       = en && dbg_active_i && !cfg_i.dbg_stop && special_i;
        exp_sel   = ovr ? 5'(MAX_EXP) : rate_exp(cfg_i.rate);
        period    = CW'(1) << (exp_sel - 5'(EXP_TRIM));
        win_start = period - (period >> 2);
        frozen    = cfg_i.dbg_stop && dbg_active_i;
        run       = en && tick_i && !frozen;
    end

    assign en_o       = en;
    assign win_mode_o = cfg_i.win_en && !ovr;
    assign win_open_o = (cnt >= win_start);
    assign expire_o   = run && (cnt >= period - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !clear_i) |=> $stable(cnt));

    // R12
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clear_i) |=> $stable(cnt));

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt == '0));

endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       win_mode_i,
    input  logic       win_open_i,
    input  logic       svc_wr_i,
    input  logic [7:0] svc_data_i,
    input  logic       flush_i,
    output logic       ok_o,
    output logic       bad_o
);

    logic      armed;
    svc_kind_t kind;

    always_comb begin
        kind  = classify(svc_wr_i && en_i, svc_data_i, armed);
        ok_o  = 1'b0;
        bad_o = 1'b0;
        if (kind != SVC_NONE) begin
            if (win_mode_i && !win_open_i) begin
                bad_o = 1'b1;
            end else begin
                ok_o  = (kind == SVC_FIRE);
                bad_o = (kind == SVC_BAD);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            armed <= 1'b0;
        end else if (kind != SVC_NONE) begin
            armed <= !bad_o && (kind == SVC_ARM);
        end
    end

    // R5
    fire_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        ok_o |-> armed);

endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdog_pkg::*;
#(
    parameter int EXP_TRIM = 0
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ctl_wr,
    input  logic       ctl_mask,
    input  logic       ctl_win,
    input  logic       ctl_dbg_stop,
    input  logic [2:0] ctl_rate,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    input  logic       dbg_active,
    input  logic       special_mode,
    output logic       rst_req
);

    ctl_req_t  req;
    wdog_cfg_t cfg;
    logic      load;
    logic      en;
    logic      win_mode;
    logic      win_open;
    logic      expire;
    logic      svc_ok;
    logic      svc_bad;
    logic      fault;

    assign req   = '{mask: ctl_mask, win_en: ctl_win, dbg_stop: ctl_dbg_stop, rate: ctl_rate};
    assign fault = expire || svc_bad;

    wdog_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (ctl_wr),
        .req_i     (req),
        .special_i (special_mode),
        .cfg_o     (cfg),
        .load_o    (load)
    );

    wdog_timer #(.EXP_TRIM(EXP_TRIM)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .cfg_i        (cfg),
        .tick_i       (tick),
        .dbg_active_i (dbg_active),
        .special_i    (special_mode),
        .clear_i      (fault || svc_ok || load),
        .en_o         (en),
        .win_mode_o   (win_mode),
        .win_open_o   (win_open),
        .expire_o     (expire)
    );

    wdog_key_seq u_key (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en),
        .win_mode_i (win_mode),
        .win_open_i (win_open),
        .svc_wr_i   (svc_wr),
        .svc_data_i (svc_data),
        .flush_i    (expire || load),
        .ok_o       (svc_ok),
        .bad_o      (svc_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= fault;
        end
    end

    // R11
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_req && !svc_wr) |=> !rst_req);

    // R6
    early_svc_chk: assert property (@(posedge clk) disable iff (rst)
        (en && win_mode && !win_open && svc_wr) |=> rst_req);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(en)) |-> !rst_req);

endmodule

// File: tb/wdog_window_bench.sv
module wdog_window_bench;

    localparam int TRIM = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       ctl_wr = 1'b0, ctl_mask = 1'b0, ctl_win = 1'b0, ctl_dbg_stop = 1'b0;
    logic [2:0] ctl_rate = 3'd0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       dbg_active = 1'b0, special_mode = 1'b0;
    logic       rst_req;
    logic       tick_alt = 1'b0;

    int checks = 0, fails = 0, pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_window #(.EXP_TRIM(TRIM)) u_wdog_window (
        .clk(clk), .rst(rst), .tick(tick), .ctl_wr(ctl_wr), .ctl_mask(ctl_mask),
        .ctl_win(ctl_win), .ctl_dbg_stop(ctl_dbg_stop), .ctl_rate(ctl_rate),
        .svc_wr(svc_wr), .svc_data(svc_data), .dbg_active(dbg_active),
        .special_mode(special_mode), .rst_req(rst_req)
    );

    always @(posedge clk) begin
        #1;
        if (rst_req) pulses++;
    end

    always @(negedge clk) if (tick_alt) tick <= ~tick;

    function automatic int period_of(int code);
        int e;
        case (code)
            1: e = 14; 2: e = 16; 3: e = 18; 4: e = 20;
            5: e = 22; 6: e = 23; default: e = 24;
        endcase
        return 1 << (e - TRIM);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_pulses(string req, int exp);
        check(pulses == exp, req, pulses, exp);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh(bit spec);
        rst = 1'b1; tick_alt = 1'b0; tick = 1'b1; dbg_active = 1'b0;
        special_mode = spec; ctl_wr = 1'b0; svc_wr = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        pulses = 0;
    endtask

    task automatic ctl_write(bit m, bit w, bit s, int r);
        ctl_wr = 1'b1; ctl_mask = m; ctl_win = w; ctl_dbg_stop = s; ctl_rate = 3'(r);
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic svc(logic [7:0] d);
        svc_wr = 1'b1; svc_data = d;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        step(2);
        fresh(1'b0);
        check(rst_req == 1'b0, "R11 reset state", int'(rst_req), 0);

        // R2: disabled, bad service values ignored
        svc(8'h12); svc(8'hAA);
        step(100);
        expect_pulses("R2 disabled quiet", 0);

        // R1 / R11: every code hits its exact edge, single pulse
        for (int c = 1; c <= 7; c++) begin
            fresh(1'b0);
            ctl_write(0, 0, 0, c);
            step(period_of(c) - 1);
            expect_pulses("R1 before timeout", 0);
            step(1);
            expect_pulses("R1 at timeout", 1);
            step(3);
            expect_pulses("R11 single pulse", 1);
        end

        // R3: random gaps around the period boundary
        for (int t = 0; t < 10; t++) begin
            int c, p, g;
            c = 1 + int'($urandom % 2);
            p = period_of(c);
            g = int'($urandom % (p + 6));
            fresh(1'b1);
            ctl_write(0, 0, 0, c);
            step(g);
            expect_pulses("R3 random gap", (g >= p) ? 1 : 0);
        end

        // R4: key sequence restarts the period
        fresh(1'b0);
        ctl_write(0, 0, 0, 1);
        step(5);
        svc(8'h55); svc(8'hAA);
        step(15);
        expect_pulses("R4 restart hold", 0);
        step(1);
        expect_pulses("R4 restart expiry", 1);

        // R5: bare 0xAA and an odd value both fault
        fresh(1'b0);
        ctl_write(0, 0, 0, 2);
        svc(8'hAA);
        expect_pulses("R5 bare fire", 1);
        step(1);
        svc(8'h33);
        expect_pulses("R5 bad value", 2);

        // R11: fault clears the pending arm and the counter
        fresh(1'b0);
        ctl_write(0, 0, 0, 2);
        svc(8'h55); svc(8'h12);
        expect_pulses("R11 fault", 1);
        svc(8'hAA);
        expect_pulses("R11 arm cleared", 2);
        step(63);
        expect_pulses("R11 counter cleared", 2);
        step(1);
        expect_pulses("R11 counter cleared expiry", 3);

        // R6: directed window, repeated arm, then closed again
        fresh(1'b0);
        ctl_write(0, 1, 0, 1);
        step(12);
        svc(8'h55); svc(8'h55); svc(8'hAA);
        expect_pulses("R6 in-window service", 0);
        svc(8'h55);
        expect_pulses("R6 window closed", 1);

        // R6: random offsets of the first key write
        for (int t = 0; t < 8; t++) begin
            int w;
            w = int'($urandom % 14);
            fresh(1'b0);
            ctl_write(0, 1, 0, 1);
            step(w);
            svc(8'h55);
            if (w < 12) begin
                expect_pulses("R6 early write", 1);
            end else begin
                svc(8'hAA);
                step(15);
                expect_pulses("R6 late service hold", 0);
                step(1);
                expect_pulses("R6 late service expiry", 1);
            end
        end

        // R7: masked write changes nothing and keeps the allowance
        fresh(1'b0);
        ctl_write(1, 0, 0, 7);
        step(40);
        expect_pulses("R7 masked no enable", 0);
        ctl_write(0, 0, 0, 1);
        step(15);
        expect_pulses("R7 allowance kept", 0);
        step(1);
        expect_pulses("R7 allowance kept expiry", 1);

        // R7 / R9: masked write sets only debug-stop, then freeze
        fresh(1'b0);
        ctl_write(0, 0, 0, 1);
        ctl_write(1, 0, 1, 7);
        dbg_active = 1'b1;
        step(30);
        expect_pulses("R7 masked stop freeze", 0);
        dbg_active = 1'b0;
        step(14);
        expect_pulses("R7 rate kept", 0);
        step(1);
        expect_pulses("R7 rate kept expiry", 1);

        // R8: normal mode write-once
        fresh(1'b0);
        ctl_write(0, 0, 0, 1);
        ctl_write(0, 0, 0, 7);
        step(14);
        expect_pulses("R8 second write ignored", 0);
        step(1);
        expect_pulses("R8 first rate kept", 1);

        // R8: special mode rewrite
        fresh(1'b1);
        ctl_write(0, 0, 0, 7);
        ctl_write(0, 0, 0, 1);
        step(15);
        expect_pulses("R8 special rewrite", 0);
        step(1);
        expect_pulses("R8 special rewrite expiry", 1);

        // R9: freeze with debug-stop set
        fresh(1'b0);
        dbg_active = 1'b1;
        ctl_write(0, 0, 1, 1);
        step(30);
        expect_pulses("R9 frozen", 0);
        dbg_active = 1'b0;
        step(15);
        expect_pulses("R9 resume", 0);
        step(1);
        expect_pulses("R9 resume expiry", 1);

        // R9: debug-stop clear keeps counting
        fresh(1'b0);
        dbg_active = 1'b1;
        ctl_write(0, 0, 0, 1);
        step(15);
        expect_pulses("R9 running in debug", 0);
        step(1);
        expect_pulses("R9 running in debug expiry", 1);

        // R10: override ignores window and short code
        fresh(1'b1);
        dbg_active = 1'b1;
        ctl_write(0, 1, 0, 1);
        svc(8'h55); svc(8'hAA);
        step(20);
        expect_pulses("R10 override no window", 0);
        step(period_of(7) - 21);
        expect_pulses("R10 long period hold", 0);
        step(1);
        expect_pulses("R10 long period expiry", 1);

        // R12: tick gating doubles the wall time
        fresh(1'b0);
        ctl_write(0, 0, 0, 1);
        tick_alt = 1'b1;
        step(26);
        expect_pulses("R12 gated hold", 0);
        step(12);
        expect_pulses("R12 gated expiry", 1);
        tick_alt = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule